// File: doc/BRIEF.md
# Option-Select Register Bank and Shared-Memory Window Decoder

This block is a small bank of eight byte-wide option registers on a host I/O bus, joined to an address decoder for a 16 KB window in a 20-bit host memory space. Two of the registers identify the card with fixed values. One holds the card-enable bit and the boot-ROM disable bit. One holds the window base as address bits 19..14, so the window moves in 16 KB steps. One stores the interrupt selection, which is only passed out to the interrupt logic. The remaining three registers are inert.

When the card is enabled and the base is in the legal range, the decoder compares each host memory address against the window. It then asserts one chip select for the region hit. The shared RAM fills the window up to the last 64 bytes. Above it, in order, sit an 8-bit address PROM, a reserved gap, a 16-bit controller data register, a control/status byte and a command byte. The block itself answers PROM and reserved-gap reads. The PROM carries the 6-byte station address on even byte offsets only.

Top module: `optsel_window`

## Requirements
- R1: I/O offset 0 reads 0xFD and I/O offset 1 reads 0x6A. Writes to either offset change nothing.
- R2: I/O offset 2 bit 0 is card enable and bit 1 is boot-ROM disable. `boot_rom_en` is the inverse of bit 1. A read returns both bits in [1:0], with zeros above.
- R3: I/O offset 3 holds the window base (host address bits 19..14) in bits [5:0]. Bits [7:6] read as zero. The value changes only on a write to offset 3.
- R4: I/O offset 4 is a full 8-bit read/write interrupt selection, driven on `irq_sel`.
- R5: I/O offsets 5, 6 and 7 read 0x00, and writes to them have no effect.
- R6: A synchronous active-high reset clears offsets 2, 3 and 4. After reset the card is disabled, the boot ROM is enabled, and the base and IRQ selection are 0.
- R7: Inside an active window, `region_cs` is one-hot by window offset: bit0 RAM 0x0000–0x3FBF, bit1 PROM 0x3FC0–0x3FDF, bit2 reserved 0x3FE0–0x3FEF, bit3 data register 0x3FF0–0x3FF1, bit4 control/status 0x3FF2, bit5 command 0x3FF3. Offsets 0x3FF4–0x3FFF select nothing.
- R8: No select is asserted while card enable is 0, or for an address whose bits 19..14 differ from the base.
- R9: A base below 0x28 (window below 0xA0000) is illegal, and no select is asserted. Bases 0x28 to 0x3F decode.
- R10: A PROM read at even offset 2·i returns station byte i for i < 6, where byte 0 is `station_addr[47:40]`. Other even PROM offsets return 0x00. In both cases `win_rdata_vld` is 1. Odd PROM offsets give `win_rdata_vld` = 0 and data 0x00.
- R11: A reserved-gap read returns 0x00 with `win_rdata_vld` = 1.
- R12: For any other address, `win_rdata_vld` is 0 and `win_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 1 | I/O access to the option bank this cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 3 | Register offset within the bank |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when io_sel is 0 |
| mem_addr | input | 20 | Host memory address |
| station_addr | input | 48 | Station address held in the PROM |
| region_cs | output | 6 | One-hot region selects |
| win_offset | output | 14 | Offset of mem_addr within the window |
| win_rdata | output | 8 | PROM / reserved read data |
| win_rdata_vld | output | 1 | win_rdata is defined for this address |
| card_en | output | 1 | Card enable bit |
| boot_rom_en | output | 1 | Boot ROM enabled |
| irq_sel | output | 8 | Stored interrupt selection |

## Verification
A corrupted base or enable bit shows at once as selects asserted for the wrong 16 KB block, or as none at all. The decoder is combinational, so this appears on the same cycle as the address. A wrong register value also shows on the very next read of that offset. The bench therefore moves the window, disables it and makes it illegal, and checks the selects and read data at each step. An off-by-one in the region boundaries or the PROM byte order appears only at the edge offsets, so the stimulus table lists those offsets explicitly.

// File: rtl/optsel_pkg.sv
package optsel_pkg;
    localparam int HOST_AW    = 20;
    localparam int WIN_AW     = 14;
    localparam int BASE_W     = HOST_AW - WIN_AW;
    localparam int NUM_CS     = 6;
    localparam int PROM_BYTES = 32;
    localparam int PROM_SLOTS = PROM_BYTES / 2;
    localparam int MAC_BYTES  = 6;
    localparam int TOP_AREA   = 64;
    localparam int WIN_SIZE   = 1 << WIN_AW;

    localparam logic [7:0] CARD_ID_LO = 8'hFD;
    localparam logic [7:0] CARD_ID_HI = 8'h6A;
    localparam logic [BASE_W-1:0] BASE_MIN = BASE_W'(6'h28);

    localparam logic [WIN_AW-1:0] PROM_START = WIN_AW'(WIN_SIZE - TOP_AREA);
    localparam logic [WIN_AW-1:0] RSVD_START = WIN_AW'(WIN_SIZE - TOP_AREA + PROM_BYTES);
    localparam logic [WIN_AW-1:0] DATA_START = WIN_AW'(WIN_SIZE - 16);
    localparam logic [WIN_AW-1:0] CTRL_OFF   = WIN_AW'(WIN_SIZE - 14);
    localparam logic [WIN_AW-1:0] CMD_OFF    = WIN_AW'(WIN_SIZE - 13);

    localparam logic [2:0] IO_ID_LO  = 3'd0;
    localparam logic [2:0] IO_ID_HI  = 3'd1;
    localparam logic [2:0] IO_ENABLE = 3'd2;
    localparam logic [2:0] IO_BASE   = 3'd3;
    localparam logic [2:0] IO_IRQ    = 3'd4;

    typedef enum logic [2:0] {
        RG_RAM  = 3'd0,
        RG_PROM = 3'd1,
        RG_RSVD = 3'd2,
        RG_DATA = 3'd3,
        RG_CTRL = 3'd4,
        RG_CMD  = 3'd5,
        RG_NONE = 3'd6
    } region_e;

    typedef struct packed {
        logic              card_en;
        logic              boot_off;
        logic [BASE_W-1:0] base;
        logic [7:0]        irq;
    } opt_cfg_t;

    function automatic region_e region_of(input logic [WIN_AW-1:0] off);
        if (off < PROM_START)      return RG_RAM;
        else if (off < RSVD_START) return RG_PROM;
        else if (off < DATA_START) return RG_RSVD;
        else if (off < CTRL_OFF)   return RG_DATA;
        else if (off == CTRL_OFF)  return RG_CTRL;
        else if (off == CMD_OFF)   return RG_CMD;
        else                       return RG_NONE;
    endfunction
endpackage

// File: rtl/optsel_regs.sv
module optsel_regs
    import optsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       io_sel,
    input  logic       io_wr,
    input  logic [2:0] io_addr,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    output opt_cfg_t   cfg
);
    logic io_we;
    assign io_we = io_sel && io_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (io_we) begin
            case (io_addr)
                IO_ENABLE: begin
                    cfg.card_en  <= io_wdata[0];
                    cfg.boot_off <= io_wdata[1];
                end
                IO_BASE: cfg.base <= io_wdata[BASE_W-1:0];
                IO_IRQ:  cfg.irq  <= io_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        io_rdata = '0;
        if (io_sel && !io_wr) begin
            case (io_addr)
                IO_ID_LO:  io_rdata = CARD_ID_LO;
                IO_ID_HI:  io_rdata = CARD_ID_HI;
                IO_ENABLE: io_rdata = {6'b0, cfg.boot_off, cfg.card_en};
                IO_BASE:   io_rdata[BASE_W-1:0] = cfg.base;
                IO_IRQ:    io_rdata = cfg.irq;
                default:   io_rdata = '0;
            endcase
        end
    end

    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(io_we && io_addr == IO_BASE) |=> $stable(cfg.base)); // R3

    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(io_we && io_addr == IO_ENABLE) |=> $stable(cfg.card_en) && $stable(cfg.boot_off)); // R2
endmodule

// File: rtl/optsel_decode.sv
module optsel_decode
    import optsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               card_en,
    input  logic [BASE_W-1:0]  base,
    input  logic [HOST_AW-1:0] mem_addr,
    output logic [NUM_CS-1:0]  cs,
    output logic [WIN_AW-1:0]  offset
);
    logic    base_ok;
    logic    hit;
    region_e rg;

    assign offset  = mem_addr[WIN_AW-1:0];
    assign base_ok = (base >= BASE_MIN);
    assign hit     = card_en && base_ok && (mem_addr[HOST_AW-1:WIN_AW] == base);
    assign rg      = region_of(offset);

    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
        assign cs[gi] = hit && (rg == region_e'(gi));
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs)); // R7

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !card_en |-> (cs == '0)); // R8

    AST_LOW_BASE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (base < BASE_MIN) |-> (cs == '0)); // R9
endmodule

// File: rtl/optsel_rdmux.sv
module optsel_rdmux
    import optsel_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cs_prom,
    input  logic                   cs_rsvd,
    input  logic [4:0]             off_lo,
    input  logic [8*MAC_BYTES-1:0] station_addr,
    output logic [7:0]             rdata,
    output logic                   rdata_vld
);
    logic [7:0] prom_img [PROM_SLOTS];

    for (genvar gi = 0; gi < PROM_SLOTS; gi++) begin : g_img
        if (gi < MAC_BYTES) begin : g_mac
            assign prom_img[gi] = station_addr[8*(MAC_BYTES-1-gi) +: 8];
        end else begin : g_pad
            assign prom_img[gi] = 8'h00;
        end
    end

    always_comb begin
        rdata     = 8'h00;
        rdata_vld = 1'b0;
        if (cs_prom && !off_lo[0]) begin
            rdata     = prom_img[off_lo[4:1]];
            rdata_vld = 1'b1;
        end else if (cs_rsvd) begin
            rdata_vld = 1'b1;
        end
    end

    AST_PROM_ODD_INVALID: assert property (@(posedge clk) disable iff (rst)
        (cs_prom && off_lo[0]) |-> !rdata_vld); // R10

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        cs_rsvd |-> (rdata_vld && rdata == 8'h00)); // R11

    AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        !(cs_prom || cs_rsvd) |-> !rdata_vld); // R12
endmodule

// File: rtl/optsel_window.sv
module optsel_window
    import optsel_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   io_sel,
    input  logic                   io_wr,
    input  logic [2:0]             io_addr,
    input  logic [7:0]             io_wdata,
    output logic [7:0]             io_rdata,
    input  logic [HOST_AW-1:0]     mem_addr,
    input  logic [8*MAC_BYTES-1:0] station_addr,
    output logic [NUM_CS-1:0]      region_cs,
    output logic [WIN_AW-1:0]      win_offset,
    output logic [7:0]             win_rdata,
    output logic                   win_rdata_vld,
    output logic                   card_en,
    output logic                   boot_rom_en,
    output logic [7:0]             irq_sel
);
    opt_cfg_t cfg;

    optsel_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .io_sel   (io_sel),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .cfg      (cfg)
    );

    optsel_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .card_en  (cfg.card_en),
        .base     (cfg.base),
        .mem_addr (mem_addr),
        .cs       (region_cs),
        .offset   (win_offset)
    );

    optsel_rdmux u_mux (
        .clk          (clk),
        .rst          (rst),
        .cs_prom      (region_cs[RG_PROM]),
        .cs_rsvd      (region_cs[RG_RSVD]),
        .off_lo       (win_offset[4:0]),
        .station_addr (station_addr),
        .rdata        (win_rdata),
        .rdata_vld    (win_rdata_vld)
    );

    assign card_en     = cfg.card_en;
    assign boot_rom_en = !cfg.boot_off;
    assign irq_sel     = cfg.irq;

    AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (region_cs != '0) |-> (card_en && mem_addr[HOST_AW-1:WIN_AW] == cfg.base)); // R8
endmodule

// File: tb/optsel_window_tb.sv
module optsel_window_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_sel = 1'b0, io_wr = 1'b0;
    logic [2:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [19:0] mem_addr = '0;
    logic [47:0] station_addr = 48'h00005A123456;
    logic [5:0]  region_cs;
    logic [13:0] win_offset;
    logic [7:0]  win_rdata;
    logic        win_rdata_vld, card_en, boot_rom_en;
    logic [7:0]  irq_sel;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    optsel_window dut_i (
        .clk(clk), .rst(rst), .io_sel(io_sel), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
        .station_addr(station_addr), .region_cs(region_cs), .win_offset(win_offset),
        .win_rdata(win_rdata), .win_rdata_vld(win_rdata_vld), .card_en(card_en),
        .boot_rom_en(boot_rom_en), .irq_sel(irq_sel)
    );

    // {addr[19:0], sel[5:0], data[7:0], vld} with base 0x33 (window 0xCC000)
    localparam int NV = 18;
    localparam logic [34:0] VEC [NV] = '{
        {20'hCC000, 6'd1,  8'h00, 1'b0},
        {20'hCFFBF, 6'd1,  8'h00, 1'b0},
        {20'hCFFC0, 6'd2,  8'h00, 1'b1},
        {20'hCFFC4, 6'd2,  8'h5A, 1'b1},
        {20'hCFFC6, 6'd2,  8'h12, 1'b1},
        {20'hCFFCA, 6'd2,  8'h56, 1'b1},
        {20'hCFFC5, 6'd2,  8'h00, 1'b0},
        {20'hCFFCC, 6'd2,  8'h00, 1'b1},
        {20'hCFFDE, 6'd2,  8'h00, 1'b1},
        {20'hCFFE0, 6'd4,  8'h00, 1'b1},
        {20'hCFFEF, 6'd4,  8'h00, 1'b1},
        {20'hCFFF0, 6'd8,  8'h00, 1'b0},
        {20'hCFFF1, 6'd8,  8'h00, 1'b0},
        {20'hCFFF2, 6'd16, 8'h00, 1'b0},
        {20'hCFFF3, 6'd32, 8'h00, 1'b0},
        {20'hCFFF4, 6'd0,  8'h00, 1'b0},
        {20'hD0000, 6'd0,  8'h00, 1'b0},
        {20'hCBFFF, 6'd0,  8'h00, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic io_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        io_sel = 1; io_wr = 1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_sel = 0; io_wr = 0;
    endtask

    task automatic io_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        io_sel = 1; io_wr = 0; io_addr = a;
        #1 d = io_rdata;
        @(negedge clk);
        io_sel = 0;
    endtask

    task automatic probe(input logic [19:0] a);
        @(negedge clk);
        mem_addr = a;
        #1;
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 0;
        // R6 reset state
        check("R6 card_en", card_en, 0);
        check("R6 boot_rom_en", boot_rom_en, 1);
        check("R6 irq_sel", irq_sel, 0);
        io_read(3'd3, rd); check("R6 base", rd, 0);
        io_read(3'd2, rd); check("R6 enable reg", rd, 0);
        // R1 ID bytes and write immunity
        io_read(3'd0, rd); check("R1 id lo", rd, 8'hFD);
        io_read(3'd1, rd); check("R1 id hi", rd, 8'h6A);
        io_write(3'd0, 8'h00); io_write(3'd1, 8'hFF);
        io_read(3'd0, rd); check("R1 id lo after write", rd, 8'hFD);
        io_read(3'd1, rd); check("R1 id hi after write", rd, 8'h6A);
        // R5 unused registers
        for (int k = 5; k < 8; k++) begin
            io_write(3'(k), 8'hA5);
            io_read(3'(k), rd); check("R5 unused reads zero", rd, 0);
        end
        check("R5 irq untouched", irq_sel, 0);
        check("R5 enable untouched", card_en, 0);
        // R4 irq
        io_write(3'd4, 8'hC3);
        io_read(3'd4, rd); check("R4 irq readback", rd, 8'hC3);
        check("R4 irq_sel port", irq_sel, 8'hC3);
        // R3 base, upper bits read zero
        io_write(3'd3, 8'hF3);
        io_read(3'd3, rd); check("R3 base readback", rd, 8'h33);
        // R8 disabled: no select inside window
        probe(20'hCC000); check("R8 disabled no select", region_cs, 0);
        // R2 enable with boot ROM disabled
        io_write(3'd2, 8'hFF);
        io_read(3'd2, rd); check("R2 enable readback", rd, 8'h03);
        check("R2 boot_rom_en off", boot_rom_en, 0);
        io_write(3'd2, 8'h01);
        check("R2 boot_rom_en on", boot_rom_en, 1);
        check("R2 card_en", card_en, 1);
        // R7 R10 R11 R12 table walk
        for (int v = 0; v < NV; v++) begin
            probe(VEC[v][34:15]);
            check("R7 region select", region_cs, VEC[v][14:9]);
            check("R10 R11 window data", win_rdata, VEC[v][8:1]);
            check("R12 window data valid", win_rdata_vld, VEC[v][0]);
        end
        // R9 illegal base 0x27, lowest legal 0x28, highest 0x3F
        io_write(3'd3, 8'h27);
        probe(20'h9C000); check("R9 illegal base", region_cs, 0);
        io_write(3'd3, 8'h28);
        probe(20'hA0000); check("R9 lowest legal base", region_cs, 6'd1);
        io_write(3'd3, 8'h3F);
        probe(20'hFFFF3); check("R9 highest base cmd", region_cs, 6'd32);
        probe(20'hA0000); check("R8 old window quiet", region_cs, 0);
        // R6 reset clears again
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        check("R6 reset clears enable", card_en, 0);
        check("R6 reset clears irq", irq_sel, 0);
        probe(20'hFFFF3); check("R6 no select after reset", region_cs, 0);
        report();
    end
endmodule